// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the upstream side of a PCI-to-PCI bridge and decides, for each request it is shown, whether the bridge should claim and forward the transaction downstream. It rebuilds three forwarding windows (I/O, non-prefetchable memory and prefetchable memory) from the packed base and limit register fields. Each window gets a fixed granularity fill on its limit and an optional upper-half extension word. The windows are gated by the command-register enable bits. When the VGA enable bit is set, the legacy display ranges are also claimed, whatever the windows hold.

A request is a single-cycle strobe with an address and a space flag (I/O or memory). One cycle later the block answers with a valid strobe, a forward flag and a one-hot code naming the window that claimed the address. The register fields are plain inputs, so configuration storage stays with the bridge's configuration logic.

Top module: `bridge_window_decoder`

## Requirements
- R1: The I/O window runs from a base whose address bits 15:12 are `io_base_reg[7:4]` up to a limit whose bits 15:12 are `io_limit_reg[7:4]`, with limit bits 11:0 all ones. When bit 0 of a base or limit register is 1 (32-bit I/O), `io_base_upper` or `io_limit_upper` respectively supplies address bits 31:16. Otherwise those bits are zero.
- R2: The memory window base has address bits 31:20 equal to `mem_base_reg[15:4]` and all other bits zero. The limit takes its bits 31:20 from `mem_limit_reg[15:4]` and has bits 19:0 all ones.
- R3: The prefetchable window is built like the memory window from `pf_base_reg`/`pf_limit_reg`. When bit 0 of either register is 1 (64-bit), `pf_base_upper` or `pf_limit_upper` respectively supplies address bits 63:32. Otherwise those bits are zero.
- R4: A window whose limit is below its base matches no address.
- R5: The I/O window matches only while `cmd_io_en` is 1. The memory and prefetchable windows match only while `cmd_mem_en` is 1.
- R6: While `vga_en` is 1, memory addresses 0xA0000–0xBFFFF match when `cmd_mem_en` is 1, and I/O addresses 0x3B0–0x3BB and 0x3C0–0x3DF match when `cmd_io_en` is 1. The full address is compared, and base/limit values play no part. While `vga_en` is 0 these ranges match only through the windows.
- R7: An I/O request (`req_is_io`=1) can hit only the I/O window or the VGA I/O ranges. A memory request can hit only the memory windows or the VGA memory range.
- R8: `rsp_hit` is one-hot or zero, with bit 0 = I/O window, bit 1 = memory window, bit 2 = prefetchable window and bit 3 = VGA range. When several match, VGA takes priority over prefetchable, prefetchable over memory, and memory over I/O. `rsp_fwd` is 1 exactly when any of them matched.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` 1. In a cycle where `rsp_valid` is 0, `rsp_fwd` and `rsp_hit` are 0.
- R10: While `rst` is 1, and in the first cycle after it, `rsp_valid`, `rsp_fwd` and `rsp_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base_reg | input | 8 | I/O base field; [7:4] address bits 15:12, [0] 32-bit flag |
| io_limit_reg | input | 8 | I/O limit field, same layout |
| io_base_upper | input | 16 | I/O base address bits 31:16 |
| io_limit_upper | input | 16 | I/O limit address bits 31:16 |
| mem_base_reg | input | 16 | Memory base; [15:4] address bits 31:20 |
| mem_limit_reg | input | 16 | Memory limit, same layout |
| pf_base_reg | input | 16 | Prefetchable base; [15:4] address bits 31:20, [0] 64-bit flag |
| pf_limit_reg | input | 16 | Prefetchable limit, same layout |
| pf_base_upper | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_upper | input | 32 | Prefetchable limit address bits 63:32 |
| cmd_io_en | input | 1 | I/O space enable |
| cmd_mem_en | input | 1 | Memory space enable |
| vga_en | input | 1 | Legacy VGA forwarding enable |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 64 | Request address |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_fwd | output | 1 | Request is claimed for forwarding |
| rsp_hit | output | 4 | One-hot matching window |

## Verification
The decoder is driven with addresses placed exactly on each window's base and limit and one step outside them. A fill or shift error shows up as an off-by-one miss or a false hit. Each upper-word flag is toggled with non-zero extension words, which separates a 16-bit I/O or 32-bit prefetchable window from its wide form. Overlapping windows, VGA ranges inside a memory window and inverted windows test the priority and zero-size rules. Random register contents with addresses drawn near the rebuilt bounds are then checked against a reference model on every clock.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int ADDR_W        = 64;
    localparam int IO_FILL_BITS  = 12;
    localparam int MEM_FILL_BITS = 20;
    localparam int NUM_WIN       = 3;
    localparam int NUM_HIT       = NUM_WIN + 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        WIN_IO  = 2'd0,
        WIN_MEM = 2'd1,
        WIN_PF  = 2'd2,
        WIN_VGA = 2'd3
    } win_e;

    typedef struct packed {
        addr_t lo;
        addr_t hi;
    } span_t;

    localparam addr_t VGA_MEM_LO = addr_t'(64'h000A_0000);
    localparam addr_t VGA_MEM_HI = addr_t'(64'h000B_FFFF);
    localparam addr_t VGA_IO1_LO = addr_t'(64'h0000_03B0);
    localparam addr_t VGA_IO1_HI = addr_t'(64'h0000_03BB);
    localparam addr_t VGA_IO2_LO = addr_t'(64'h0000_03C0);
    localparam addr_t VGA_IO2_HI = addr_t'(64'h0000_03DF);

    function automatic addr_t io_edge(logic [7:0] field, logic [15:0] upper, logic fill);
        addr_t a;
        a = '0;
        a[15:12] = field[7:4];
        if (field[0]) a[31:16] = upper;
        if (fill) a[IO_FILL_BITS-1:0] = '1;
        return a;
    endfunction

    function automatic addr_t mem_edge(logic [15:0] field, logic fill);
        addr_t a;
        a = '0;
        a[31:20] = field[15:4];
        if (fill) a[MEM_FILL_BITS-1:0] = '1;
        return a;
    endfunction

    function automatic addr_t pf_edge(logic [15:0] field, logic [31:0] upper, logic fill);
        addr_t a;
        a = mem_edge(field, fill);
        if (field[0]) a[63:32] = upper;
        return a;
    endfunction

    function automatic logic in_span(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [NUM_HIT-1:0] pick_one(logic [NUM_HIT-1:0] raw);
        logic [NUM_HIT-1:0] r;
        r = '0;
        for (int i = NUM_HIT - 1; i >= 0; i--) begin
            if (raw[i] && (r == '0)) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bwd_window_build.sv
module bwd_window_build
    import bwd_pkg::*;
(
    input  logic [7:0]              io_base_reg,
    input  logic [7:0]              io_limit_reg,
    input  logic [15:0]             io_base_upper,
    input  logic [15:0]             io_limit_upper,
    input  logic [15:0]             mem_base_reg,
    input  logic [15:0]             mem_limit_reg,
    input  logic [15:0]             pf_base_reg,
    input  logic [15:0]             pf_limit_reg,
    input  logic [31:0]             pf_base_upper,
    input  logic [31:0]             pf_limit_upper,
    input  logic                    cmd_io_en,
    input  logic                    cmd_mem_en,
    output span_t [NUM_WIN-1:0]     spans,
    output logic  [NUM_WIN-1:0]     span_on
);

    logic [NUM_WIN-1:0] space_on;

    always_comb begin
        spans[WIN_IO].lo  = io_edge(io_base_reg,  io_base_upper,  1'b0);
        spans[WIN_IO].hi  = io_edge(io_limit_reg, io_limit_upper, 1'b1);
        spans[WIN_MEM].lo = mem_edge(mem_base_reg,  1'b0);
        spans[WIN_MEM].hi = mem_edge(mem_limit_reg, 1'b1);
        spans[WIN_PF].lo  = pf_edge(pf_base_reg,  pf_base_upper,  1'b0);
        spans[WIN_PF].hi  = pf_edge(pf_limit_reg, pf_limit_upper, 1'b1);
        space_on[WIN_IO]  = cmd_io_en;
        space_on[WIN_MEM] = cmd_mem_en;
        space_on[WIN_PF]  = cmd_mem_en;
    end

    // A window is live only when its space is enabled and it is not inverted.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_on
        assign span_on[w] = space_on[w] && (spans[w].hi >= spans[w].lo);
    end

endmodule

// File: rtl/bwd_range_match.sv
module bwd_range_match
    import bwd_pkg::*;
#(
    parameter int N = NUM_WIN
) (
    input  addr_t              addr,
    input  span_t [N-1:0]      spans,
    input  logic  [N-1:0]      span_on,
    output logic  [N-1:0]      hit
);

    for (genvar w = 0; w < N; w++) begin : g_cmp
        assign hit[w] = span_on[w] && in_span(addr, spans[w].lo, spans[w].hi);
    end

endmodule

// File: rtl/bwd_vga_match.sv
module bwd_vga_match
    import bwd_pkg::*;
(
    input  addr_t addr,
    input  logic  is_io,
    input  logic  vga_en,
    input  logic  cmd_io_en,
    input  logic  cmd_mem_en,
    output logic  vga_hit
);

    logic io_in, mem_in;

    always_comb begin
        io_in  = in_span(addr, VGA_IO1_LO, VGA_IO1_HI) || in_span(addr, VGA_IO2_LO, VGA_IO2_HI);
        mem_in = in_span(addr, VGA_MEM_LO, VGA_MEM_HI);
        if (!vga_en)  vga_hit = 1'b0;
        else if (is_io) vga_hit = cmd_io_en && io_in;
        else            vga_hit = cmd_mem_en && mem_in;
    end

endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
    import bwd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          io_base_reg,
    input  logic [7:0]          io_limit_reg,
    input  logic [15:0]         io_base_upper,
    input  logic [15:0]         io_limit_upper,
    input  logic [15:0]         mem_base_reg,
    input  logic [15:0]         mem_limit_reg,
    input  logic [15:0]         pf_base_reg,
    input  logic [15:0]         pf_limit_reg,
    input  logic [31:0]         pf_base_upper,
    input  logic [31:0]         pf_limit_upper,
    input  logic                cmd_io_en,
    input  logic                cmd_mem_en,
    input  logic                vga_en,
    input  logic                req_valid,
    input  logic                req_is_io,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    output logic                rsp_fwd,
    output logic [NUM_HIT-1:0]  rsp_hit
);

    span_t [NUM_WIN-1:0] spans;
    logic  [NUM_WIN-1:0] span_on;
    logic  [NUM_WIN-1:0] win_hit;
    logic                vga_hit;
    logic  [NUM_HIT-1:0] raw_hit;
    logic  [NUM_HIT-1:0] sel_hit;

    bwd_window_build u_build (
        .io_base_reg    (io_base_reg),
        .io_limit_reg   (io_limit_reg),
        .io_base_upper  (io_base_upper),
        .io_limit_upper (io_limit_upper),
        .mem_base_reg   (mem_base_reg),
        .mem_limit_reg  (mem_limit_reg),
        .pf_base_reg    (pf_base_reg),
        .pf_limit_reg   (pf_limit_reg),
        .pf_base_upper  (pf_base_upper),
        .pf_limit_upper (pf_limit_upper),
        .cmd_io_en      (cmd_io_en),
        .cmd_mem_en     (cmd_mem_en),
        .spans          (spans),
        .span_on        (span_on)
    );

    bwd_range_match #(.N(NUM_WIN)) u_match (
        .addr    (req_addr),
        .spans   (spans),
        .span_on (span_on),
        .hit     (win_hit)
    );

    bwd_vga_match u_vga (
        .addr       (req_addr),
        .is_io      (req_is_io),
        .vga_en     (vga_en),
        .cmd_io_en  (cmd_io_en),
        .cmd_mem_en (cmd_mem_en),
        .vga_hit    (vga_hit)
    );

    // Space qualification: I/O requests see only the I/O window, memory
    // requests see only the two memory windows.
    always_comb begin
        raw_hit          = '0;
        raw_hit[WIN_IO]  = win_hit[WIN_IO]  &&  req_is_io;
        raw_hit[WIN_MEM] = win_hit[WIN_MEM] && !req_is_io;
        raw_hit[WIN_PF]  = win_hit[WIN_PF]  && !req_is_io;
        raw_hit[WIN_VGA] = vga_hit;
        sel_hit          = pick_one(raw_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fwd   <= 1'b0;
            rsp_hit   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fwd   <= req_valid && (raw_hit != '0);
            rsp_hit   <= req_valid ? sel_hit : '0;
        end
    end

    assert_hit_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_hit) && (rsp_fwd == (rsp_hit != '0)));

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_fwd && rsp_hit == '0));

    assert_mem_req_no_io_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_io) |=> !rsp_hit[WIN_IO]);

    assert_io_req_no_mem_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io) |=> (!rsp_hit[WIN_MEM] && !rsp_hit[WIN_PF]));

    assert_mem_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cmd_mem_en) |=> (!rsp_hit[WIN_MEM] && !rsp_hit[WIN_PF]));

    assert_io_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cmd_io_en) |=> !rsp_hit[WIN_IO]);

endmodule

// File: tb/test_bridge_window_decoder.sv
module test_bridge_window_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  io_base_reg, io_limit_reg;
    logic [15:0] io_base_upper, io_limit_upper;
    logic [15:0] mem_base_reg, mem_limit_reg, pf_base_reg, pf_limit_reg;
    logic [31:0] pf_base_upper, pf_limit_upper;
    logic        cmd_io_en, cmd_mem_en, vga_en;
    logic        req_valid, req_is_io;
    logic [63:0] req_addr;
    logic        rsp_valid, rsp_fwd;
    logic [3:0]  rsp_hit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bridge_window_decoder i_bridge_window_decoder (
        .clk(clk), .rst(rst),
        .io_base_reg(io_base_reg), .io_limit_reg(io_limit_reg),
        .io_base_upper(io_base_upper), .io_limit_upper(io_limit_upper),
        .mem_base_reg(mem_base_reg), .mem_limit_reg(mem_limit_reg),
        .pf_base_reg(pf_base_reg), .pf_limit_reg(pf_limit_reg),
        .pf_base_upper(pf_base_upper), .pf_limit_upper(pf_limit_upper),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .vga_en(vga_en),
        .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_hit(rsp_hit)
    );

    // Reference bounds, computed arithmetically from the register fields.
    longint unsigned io_lo, io_hi, m_lo, m_hi, p_lo, p_hi;

    function automatic void bounds();
        longint unsigned mb = 1048576;
        io_lo = longint'(io_base_reg / 16) * 4096;
        if (io_base_reg % 2 == 1) io_lo += longint'(io_base_upper) * 65536;
        io_hi = longint'(io_limit_reg / 16) * 4096 + 4095;
        if (io_limit_reg % 2 == 1) io_hi += longint'(io_limit_upper) * 65536;
        m_lo = longint'(mem_base_reg / 16) * mb;
        m_hi = longint'(mem_limit_reg / 16) * mb + mb - 1;
        p_lo = longint'(pf_base_reg / 16) * mb;
        if (pf_base_reg % 2 == 1) p_lo += longint'(pf_base_upper) << 32;
        p_hi = longint'(pf_limit_reg / 16) * mb + mb - 1;
        if (pf_limit_reg % 2 == 1) p_hi += longint'(pf_limit_upper) << 32;
    endfunction

    function automatic logic [3:0] ref_hit(bit is_io, longint unsigned a);
        bit v_vga, v_pf, v_mem, v_io;
        bounds();
        v_io  = is_io && cmd_io_en && a >= io_lo && a <= io_hi;
        v_mem = !is_io && cmd_mem_en && a >= m_lo && a <= m_hi;
        v_pf  = !is_io && cmd_mem_en && a >= p_lo && a <= p_hi;
        v_vga = vga_en && (is_io ? (cmd_io_en && ((a >= 'h3B0 && a <= 'h3BB) || (a >= 'h3C0 && a <= 'h3DF)))
                                 : (cmd_mem_en && a >= 'hA0000 && a <= 'hBFFFF));
        if (v_vga) return 4'b1000;
        if (v_pf)  return 4'b0100;
        if (v_mem) return 4'b0010;
        if (v_io)  return 4'b0001;
        return 4'b0000;
    endfunction

    task automatic compare(string tag, bit ev, bit ef, logic [3:0] eh);
        checks++;
        if (rsp_valid !== ev || rsp_fwd !== ef || rsp_hit !== eh) begin
            errors++;
            $display("FAIL %s: got valid=%0b fwd=%0b hit=%b, expected valid=%0b fwd=%0b hit=%b",
                     tag, rsp_valid, rsp_fwd, rsp_hit, ev, ef, eh);
        end
    endtask

    // Drive at a falling edge, result is registered at the next rising edge,
    // sampled at the following falling edge.
    task automatic step(string tag, bit v, bit is_io, longint unsigned a);
        logic [3:0] eh;
        req_valid = v; req_is_io = is_io; req_addr = a;
        eh = v ? ref_hit(is_io, a) : 4'b0000;
        @(posedge clk);
        @(negedge clk);
        compare(tag, v, eh != 0, eh);
    endtask

    task automatic clear_cfg();
        io_base_reg = 8'hF0; io_limit_reg = 8'h00; io_base_upper = 0; io_limit_upper = 0;
        mem_base_reg = 16'hFFF0; mem_limit_reg = 16'h0000;
        pf_base_reg = 16'hFFF0; pf_limit_reg = 16'h0000; pf_base_upper = 0; pf_limit_upper = 0;
        cmd_io_en = 1; cmd_mem_en = 1; vga_en = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_cfg();
        rst = 1; req_valid = 1; req_is_io = 0; req_addr = 0;
        repeat (3) @(negedge clk);
        compare("R10 in reset", 0, 0, 4'b0000);
        req_valid = 0;
        @(negedge clk);
        rst = 0;
        @(posedge clk); @(negedge clk);
        compare("R10 after reset", 0, 0, 4'b0000);

        // R1: 16-bit I/O window 0x2000..0x3FFF
        io_base_reg = 8'h20; io_limit_reg = 8'h30; io_base_upper = 16'h5; io_limit_upper = 16'h5;
        step("R1 io base", 1, 1, 'h2000);
        step("R1 io limit", 1, 1, 'h3FFF);
        step("R1 io above", 1, 1, 'h4000);
        step("R1 io below", 1, 1, 'h1FFF);
        step("R1 io upper ignored", 1, 1, 'h5_2000);
        // R1: 32-bit I/O window 0x12000..0x12FFF
        io_base_reg = 8'h21; io_limit_reg = 8'h21; io_base_upper = 16'h1; io_limit_upper = 16'h1;
        step("R1 io32 inside", 1, 1, 'h12800);
        step("R1 io32 limit", 1, 1, 'h12FFF);
        step("R1 io32 low alias", 1, 1, 'h2800);

        // R2: memory 0x1230_0000..0x124F_FFFF
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
        step("R2 mem base", 1, 0, 'h1230_0000);
        step("R2 mem limit", 1, 0, 'h124F_FFFF);
        step("R2 mem above", 1, 0, 'h1250_0000);
        step("R2 mem below", 1, 0, 'h122F_FFFF);

        // R3: 64-bit prefetchable 0x1_4000_0000..0x1_400F_FFFF
        pf_base_reg = 16'h4001; pf_limit_reg = 16'h4001; pf_base_upper = 1; pf_limit_upper = 1;
        step("R3 pf64 base", 1, 0, 'h1_4000_0000);
        step("R3 pf64 limit", 1, 0, 'h1_400F_FFFF);
        step("R3 pf64 low alias", 1, 0, 'h4000_0000);
        pf_base_reg = 16'h4000; pf_limit_reg = 16'h4000;
        step("R3 pf32 inside", 1, 0, 'h4008_0000);
        step("R3 pf32 upper ignored", 1, 0, 'h1_4008_0000);

        // R8: memory and prefetchable overlap -> prefetchable
        mem_base_reg = 16'h4000; mem_limit_reg = 16'h4000;
        step("R8 overlap pf wins", 1, 0, 'h4000_0000);

        // R4: inverted windows
        mem_base_reg = 16'h2000; mem_limit_reg = 16'h1000;
        pf_base_reg = 16'h3000; pf_limit_reg = 16'h2FF0;
        step("R4 mem inverted", 1, 0, 'h2000_0000);
        step("R4 pf inverted", 1, 0, 'h3000_0000);
        io_base_reg = 8'h80; io_limit_reg = 8'h70;
        step("R4 io inverted", 1, 1, 'h8000);

        // R5: enables
        io_base_reg = 8'h20; io_limit_reg = 8'h30;
        mem_base_reg = 16'h1230; mem_limit_reg = 16'h1240;
        cmd_io_en = 0;
        step("R5 io disabled", 1, 1, 'h2000);
        cmd_io_en = 1; cmd_mem_en = 0;
        step("R5 mem disabled", 1, 0, 'h1230_0000);
        step("R5 io still on", 1, 1, 'h2000);
        cmd_mem_en = 1;

        // R7: wrong space
        step("R7 mem req at io window", 1, 0, 'h2000);
        step("R7 io req at mem window", 1, 1, 'h1230_0000);

        // R6: VGA ranges
        step("R6 vga off", 1, 0, 'hA0000);
        vga_en = 1;
        step("R6 vga mem below", 1, 0, 'h9FFFF);
        step("R6 vga mem lo", 1, 0, 'hA0000);
        step("R6 vga mem hi", 1, 0, 'hBFFFF);
        step("R6 vga mem above", 1, 0, 'hC0000);
        step("R6 vga io1 lo", 1, 1, 'h3B0);
        step("R6 vga io1 hi", 1, 1, 'h3BB);
        step("R6 vga io gap", 1, 1, 'h3BC);
        step("R6 vga io2 lo", 1, 1, 'h3C0);
        step("R6 vga io2 hi", 1, 1, 'h3DF);
        step("R6 vga io above", 1, 1, 'h3E0);
        step("R6 vga io alias", 1, 1, 'h1_03C0);
        step("R7 vga io addr as mem", 1, 0, 'h3C0);
        cmd_io_en = 0;
        step("R6 vga io gated", 1, 1, 'h3C0);
        cmd_io_en = 1;
        // R8: VGA inside memory window -> VGA wins
        mem_base_reg = 16'h0000; mem_limit_reg = 16'h0010;
        step("R8 vga over mem", 1, 0, 'hB0000);
        step("R8 mem outside vga", 1, 0, 'h10_0000);
        // R8: VGA I/O inside I/O window
        io_base_reg = 8'h00; io_limit_reg = 8'h00;
        step("R8 vga over io", 1, 1, 'h3C4);
        step("R8 io outside vga", 1, 1, 'h100);

        // R9: idle cycles and back-to-back
        step("R9 idle", 0, 0, 'hB0000);
        step("R9 back to back a", 1, 0, 'hB0000);
        step("R9 back to back b", 1, 1, 'h100);
        step("R9 idle again", 0, 1, 'h100);

        // Random configurations with addresses near rebuilt bounds
        for (int n = 0; n < 400; n++) begin
            longint unsigned pick;
            longint unsigned a;
            bit is_io;
            io_base_reg = 8'($urandom); io_limit_reg = 8'($urandom);
            io_base_upper = 16'($urandom % 4); io_limit_upper = 16'($urandom % 4);
            mem_base_reg = 16'($urandom % 512); mem_limit_reg = 16'($urandom % 512);
            pf_base_reg = 16'($urandom % 512); pf_limit_reg = 16'($urandom % 512);
            pf_base_upper = $urandom % 3; pf_limit_upper = $urandom % 3;
            cmd_io_en = ($urandom % 4) != 0; cmd_mem_en = ($urandom % 4) != 0;
            vga_en = $urandom % 2;
            bounds();
            is_io = $urandom % 2;
            case ($urandom % 5)
                0: pick = is_io ? io_lo : m_lo;
                1: pick = is_io ? io_hi : m_hi;
                2: pick = is_io ? 'h3C0 : p_lo;
                3: pick = is_io ? 'h3BB : p_hi;
                default: pick = is_io ? longint'($urandom % 'h2_0000) : 'hA0000;
            endcase
            a = pick + longint'($urandom % 3) - 1;
            step("R1-mix random", ($urandom % 8) != 0, is_io, a);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule